// File: doc/BRIEF.md
# Dual-Pattern Paced Stepper

This block drives a 4-bit value through one of two fixed five-value patterns. One pattern is 0, 1, 2, 4, 8. The other is 0, 5, 7, 11, 13. After the last value of either pattern, the output returns to 0. A free-running modulo-N tick generator paces the steps. N is derived from the clock frequency and the step period, so with the default parameters the output moves every half second. The output advances only on a clock edge where the tick pulse and the user run enable are both high.

A one-bit pattern select input picks the pattern. It is latched in two cases only: at reset, and on the step that wraps from the last position back to position 0. A pattern that has started therefore always runs to its end before a new choice takes effect. Clearing the run enable freezes the position. The tick generator keeps running during the pause, so when stepping resumes it stays on the original N-cycle grid.

The state machine has five states, `POS_0` to `POS_4`, one for each position in the pattern. It has three transitions. `ADVANCE` moves one state forward on an enabled tick when the current state is not `POS_4`. `WRAP` goes from `POS_4` to `POS_0` on an enabled tick and latches the select. `HOLD` keeps the current state on any other edge. Reset forces `POS_0`.

Top module: `dual_pattern_stepper`

## Requirements
- R1: A rising edge with `rst` high forces `count_out` to 0 and clears the tick counter. With `run_en` held high, the first step then happens on the N-th rising edge after the last reset edge.
- R2: When the latched select is 0, `count_out` runs 0, 1, 2, 4, 8 and then returns to 0.
- R3: When the latched select is 1, `count_out` runs 0, 5, 7, 11, 13 and then returns to 0.
- R4: The tick is one clock cycle wide and recurs every N = CLK_FREQ_HZ/1000*STEP_PERIOD_MS cycles. `count_out` can change only on an edge where the tick is high.
- R5: If `run_en` is low on a tick edge, the position holds. The tick counter keeps counting through the pause, so later steps stay on the same N-cycle grid.
- R6: `pattern_sel` is latched only on the step from `POS_4` to `POS_0`. Changes at any other time have no effect on `count_out` until that wrap.
- R7: `pattern_sel` is also latched on every reset edge, and that value selects the pattern that follows the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Step enable; low pauses the position |
| pattern_sel | input | 1 | Pattern choice: 0 powers of two, 1 the odd pattern |
| count_out | output | 4 | Current pattern value |

## Verification
The bench builds the block with N = 4 and compares `count_out` on every cycle against an arithmetic model. It first runs each pattern continuously with `run_en` high. This separates the two value tables and confirms the wrap to 0. It then flips `pattern_sel` in the middle of a pattern and on the wrap cycle itself, which shows whether the select is latched at the wrap or sampled continuously. Further runs include pauses longer than N, sweeps of enable and select bit patterns, and resets in mid-pattern with each select value. These show whether the tick grid survives a pause and whether reset latches the select.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [2:0] {
        POS_0 = 3'd0,
        POS_1 = 3'd1,
        POS_2 = 3'd2,
        POS_3 = 3'd3,
        POS_4 = 3'd4
    } pos_e;

    localparam int unsigned VALUE_W = 4;

endpackage

// File: rtl/dps_tick_gen.sv
module dps_tick_gen #(
    parameter int unsigned TICK_N = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CNT_W = (TICK_N > 2) ? $clog2(TICK_N) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_N - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: the pulse lasts a single cycle
    assert_tick_single_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R4: after a pulse, counting restarts from zero
    assert_tick_restart_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/dps_step_fsm.sv
module dps_step_fsm
    import dps_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               run_en,
    input  logic               pattern_sel,
    output logic [VALUE_W-1:0] count_out
);
    pos_e state_q, state_d;
    logic seq_q, seq_d;
    logic step;

    assign step = tick & run_en;

    // next state and select latch
    always_comb begin
        state_d = state_q;
        seq_d   = seq_q;
        if (step) begin
            unique case (state_q)
                POS_0:   state_d = POS_1;
                POS_1:   state_d = POS_2;
                POS_2:   state_d = POS_3;
                POS_3:   state_d = POS_4;
                POS_4: begin
                    state_d = POS_0;
                    seq_d   = pattern_sel;
                end
                default: state_d = POS_0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= POS_0;
            seq_q   <= pattern_sel;
        end else begin
            state_q <= state_d;
            seq_q   <= seq_d;
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            POS_0:   count_out = 4'd0;
            POS_1:   count_out = seq_q ? 4'd5  : 4'd1;
            POS_2:   count_out = seq_q ? 4'd7  : 4'd2;
            POS_3:   count_out = seq_q ? 4'd11 : 4'd4;
            POS_4:   count_out = seq_q ? 4'd13 : 4'd8;
            default: count_out = 4'd0;
        endcase
    end

    // R5: without an enabled tick the position holds
    assert_hold_no_step_R5: assert property (@(posedge clk) disable iff (rst)
        !(tick && run_en) |=> $stable(state_q));

    // R2: an enabled tick in the last position returns to the start
    assert_wrap_to_start_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && run_en && state_q == POS_4) |=> (state_q == POS_0));

    // R6: the pattern latch only moves on a wrap
    assert_sel_latched_on_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        !(tick && run_en && state_q == POS_4) |=> $stable(seq_q));

endmodule

// File: rtl/dual_pattern_stepper.sv
module dual_pattern_stepper #(
    parameter int unsigned CLK_FREQ_HZ    = 50_000_000,
    parameter int unsigned STEP_PERIOD_MS = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic       pattern_sel,
    output logic [3:0] count_out
);
    localparam int unsigned TICK_N = (CLK_FREQ_HZ / 1000) * STEP_PERIOD_MS;

    logic tick;

    dps_tick_gen #(
        .TICK_N (TICK_N)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dps_step_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .run_en      (run_en),
        .pattern_sel (pattern_sel),
        .count_out   (count_out)
    );

    // R1: a reset edge leaves the output at zero
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (count_out == 4'd0));

    // R4: the output moves only on a tick edge
    assert_change_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count_out));

    // R3: only values from the two patterns appear
    assert_value_legal_R3: assert property (@(posedge clk) disable iff (rst)
        count_out inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd8, 4'd5, 4'd7, 4'd11, 4'd13});

endmodule

// File: tb/dual_pattern_stepper_bench.sv
module dual_pattern_stepper_bench;

    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       run_en;
    logic       pattern_sel;
    logic [3:0] count_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc_no   = 0;
    string tag   = "R1";

    int m_cnt;
    int m_pos;
    int m_sel;

    always #10 clk = ~clk;

    dual_pattern_stepper #(
        .CLK_FREQ_HZ    (4000),
        .STEP_PERIOD_MS (1)
    ) u_dual_pattern_stepper (
        .clk         (clk),
        .rst         (rst),
        .run_en      (run_en),
        .pattern_sel (pattern_sel),
        .count_out   (count_out)
    );

    function automatic int expect_val(int pos, int sel);
        if (pos == 0) return 0;
        if (sel == 0) return 1 << (pos - 1);
        case (pos)
            1: return 5;
            2: return 7;
            3: return 11;
            default: return 13;
        endcase
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // model update for the edge that samples the given inputs
    task automatic model_edge(logic r, logic e, logic s);
        if (r) begin
            m_cnt = 0;
            m_pos = 0;
            m_sel = s;
        end else begin
            if (m_cnt == N - 1) begin
                m_cnt = 0;
                if (e) begin
                    if (m_pos == 4) begin
                        m_pos = 0;
                        m_sel = s;
                    end else begin
                        m_pos = m_pos + 1;
                    end
                end
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    endtask

    task automatic cyc(logic r, logic e, logic s);
        int ev;
        @(negedge clk);
        cyc_no++;
        ev = expect_val(m_pos, m_sel);
        n_checks++;
        if (count_out !== 4'(ev)) begin
            n_fail++;
            $display("FAIL %s cycle %0d: count_out=%0d expected %0d", tag, cyc_no, count_out, ev);
        end
        rst         = r;
        run_en      = e;
        pattern_sel = s;
        model_edge(r, e, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; run_en = 1'b1; pattern_sel = 1'b0;
        model_edge(1'b1, 1'b1, 1'b0);

        // R1: reset state, then first step on the N-th edge
        tag = "R1";
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < N + 2; i++) cyc(1'b0, 1'b1, 1'b0);

        // R2: two full powers-of-two patterns
        tag = "R2";
        for (int i = 0; i < 10 * N; i++) cyc(1'b0, 1'b1, 1'b0);

        // R6: select raised mid-pattern, held until and past the wrap
        tag = "R6";
        for (int i = 0; i < 6 * N; i++) cyc(1'b0, 1'b1, 1'b1);

        // R3: odd pattern, two full runs
        tag = "R3";
        for (int i = 0; i < 10 * N; i++) cyc(1'b0, 1'b1, 1'b1);

        // R6: select toggling every cycle, including the wrap edges
        tag = "R6";
        for (int i = 0; i < 12 * N; i++) cyc(1'b0, 1'b1, 1'(i & 1));

        // R5: long pause mid-pattern, then resume on the same grid
        tag = "R5";
        for (int i = 0; i < 2 * N + 1; i++) cyc(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 3 * N + 1; i++) cyc(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 6 * N; i++) cyc(1'b0, 1'b1, 1'b0);

        // R4: sweep of enable and select bit patterns
        tag = "R4";
        for (int p = 0; p < 16; p++) begin
            for (int i = 0; i < 8 * N; i++)
                cyc(1'b0, 1'((p >> (i % 4)) & 1), 1'((p >> ((i + 1) % 4)) & 1));
        end

        // R7: mid-pattern reset with select 1, then with select 0
        tag = "R7";
        for (int i = 0; i < 2 * N; i++) cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 6 * N; i++) cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 6 * N; i++) cyc(1'b0, 1'b1, 1'b1);

        summary();
        $finish;
    end

endmodule